// File: doc/BRIEF.md
# Windowed Register File

This block holds the architectural registers of a 32-bit processor core. Every operand address is a 6-bit code. Its top bit decides which of two spaces is reached. When that bit is clear, the remaining five bits index a bank of general-purpose registers. When it is set, the access lands in a four-entry special window that holds two scratch words, the program counter and the condition-flag word.

Two read ports return data combinationally. One write port updates state on the rising clock edge. The four condition flags can be set or cleared one at a time from dedicated inputs, and the program counter has its own step input. An access to a general register index that the bank does not implement is refused. A refused read returns zero, a refused write changes nothing, and both raise a sticky error bit that stays set until it is cleared on purpose.

Top module: `regwin_file`

## Requirements
- R1: With address bit 5 clear, bits 4:0 select a general register. With bit 5 set, bits 1:0 select a special register (0 scratch G, 1 scratch D, 2 program counter, 3 flag word), and bits 4:2 are ignored.
- R2: Both read ports are combinational and independent of each other. A write with `wr_en` high takes effect on the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R3: A general index at or above `NUM_GPR` is illegal. Reading it returns zero, and writing it leaves every register unchanged.
- R4: `reg_err` rises on the edge after an illegal access, which is an illegal write with `wr_en` high or a read of an illegal index with that port's enable high. It then stays high until `err_clr` or reset. If a new illegal access arrives in the same cycle as `err_clr`, the error stays set.
- R5: The flag word holds overflow in bit 0, zero in bit 1, sign in bit 2 and parity in bit 3, and it reads back with bits 31:4 at zero. `flag_set[i]` and `flag_clr[i]` change only bit i. Set wins over clear. Both apply on top of a same-cycle write to the flag word.
- R6: A write through the special window changes only the selected special register.
- R7: `pc_inc` adds one to the program counter. A same-cycle write to the program counter wins over the increment.
- R8: Synchronous active-high `rst` clears all general registers, both scratch registers, the program counter, the flag word and `reg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_a | input | 1 | Read port A is in use (gates error reporting) |
| rd_addr_a | input | 6 | Read port A operand address |
| rd_data_a | output | 32 | Read port A data |
| rd_en_b | input | 1 | Read port B is in use (gates error reporting) |
| rd_addr_b | input | 6 | Read port B operand address |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write operand address |
| wr_data | input | 32 | Write data |
| flag_set | input | 4 | Per-bit flag set |
| flag_clr | input | 4 | Per-bit flag clear |
| pc_inc | input | 1 | Step the program counter by one |
| err_clr | input | 1 | Clear the sticky error |
| reg_err | output | 1 | Sticky illegal-access error |
| pc_value | output | 32 | Current program counter |
| flag_value | output | 4 | Current flag word |

## Verification
The bench builds the block with `NUM_GPR` set to 24 and the other parameters at their defaults. This leaves indices 24 to 31 unimplemented. At the default of 32, every 5-bit index is legal, so the refusal path and the sticky error could never be exercised. The reduced bank makes it possible to check both refused reads and refused writes. It also covers the race between a new illegal access and an error clear, and it confirms that a refused write does not alias onto an implemented register.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Special-window selector, decoded from the low two address bits.
  typedef enum logic [1:0] {
    SP_G    = 2'd0,
    SP_D    = 2'd1,
    SP_PC   = 2'd2,
    SP_FLAG = 2'd3
  } spec_sel_e;

  // Condition-flag layout.
  localparam int FLAG_W   = 4;
  localparam int FLG_OVF  = 0;
  localparam int FLG_ZERO = 1;
  localparam int FLG_SIGN = 2;
  localparam int FLG_PAR  = 3;

endpackage

// File: rtl/regwin_addr_dec.sv
module regwin_addr_dec
  import regwin_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NUM_GPR = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_spec,
  output logic              bad_idx,
  output logic [ADDR_W-2:0] gpr_idx,
  output spec_sel_e         sel
);
  localparam int          IDX_W = ADDR_W - 1;
  localparam logic [31:0] LIMIT = NUM_GPR;

  assign is_spec = addr[ADDR_W-1];
  assign gpr_idx = addr[IDX_W-1:0];
  assign sel     = spec_sel_e'(addr[1:0]);

  // Only a partly populated bank can see an illegal index.
  generate
    if (NUM_GPR < (1 << IDX_W)) begin : g_partial
      assign bad_idx = !is_spec && (32'(gpr_idx) >= LIMIT);
    end else begin : g_full
      assign bad_idx = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/regwin_gpr_bank.sv
module regwin_gpr_bank #(
  parameter int DATA_W  = 32,
  parameter int NUM_GPR = 32,
  parameter int IDX_W   = 5,
  parameter int NRD     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx  [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  localparam logic [31:0] LIMIT = NUM_GPR;

  logic [DATA_W-1:0] mem [NUM_GPR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_GPR; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
        if (32'(ridx[p]) < LIMIT) rdata[p] = mem[ridx[p]];
        else                      rdata[p] = '0;
      end
    end
  endgenerate

  // R2: an accepted write is visible at its index on the next cycle.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(widx)] == $past(wdata));

endmodule

// File: rtl/regwin_spec_regs.sv
module regwin_spec_regs
  import regwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  spec_sel_e         sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic              pc_inc,
  output logic [DATA_W-1:0] g_q,
  output logic [DATA_W-1:0] d_q,
  output logic [DATA_W-1:0] pc_q,
  output logic [FLAG_W-1:0] flag_q
);
  logic              pc_we, flag_we;
  logic [FLAG_W-1:0] flag_base, flag_next;

  assign pc_we   = we && (sel == SP_PC);
  assign flag_we = we && (sel == SP_FLAG);

  always_comb begin
    flag_base = flag_we ? wdata[FLAG_W-1:0] : flag_q;
    flag_next = (flag_base & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      g_q    <= '0;
      d_q    <= '0;
      pc_q   <= '0;
      flag_q <= '0;
    end else begin
      if (we && sel == SP_G) g_q <= wdata;
      if (we && sel == SP_D) d_q <= wdata;
      if (pc_we)       pc_q <= wdata;
      else if (pc_inc) pc_q <= pc_q + DATA_W'(1);
      flag_q <= flag_next;
    end
  end

  // R5: with no write to the flag word and no set or clear, the flags hold.
  p_flag_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!flag_we && flag_set == '0 && flag_clr == '0) |=> $stable(flag_q));

  // R7: a step without a competing write advances the counter by one.
  p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
    (pc_inc && !pc_we) |=> pc_q == $past(pc_q) + DATA_W'(1));

  // R6: writing scratch G leaves the other special registers alone.
  p_spec_isolate_r6: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SP_G && !pc_inc && flag_set == '0 && flag_clr == '0)
      |=> ($stable(d_q) && $stable(pc_q) && $stable(flag_q)));

endmodule

// File: rtl/regwin_file.sv
module regwin_file
  import regwin_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6,
  parameter int NUM_GPR = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_a,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic              rd_en_b,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic [FLAG_W-1:0] flag_clr,
  input  logic              pc_inc,
  input  logic              err_clr,
  output logic              reg_err,
  output logic [DATA_W-1:0] pc_value,
  output logic [FLAG_W-1:0] flag_value
);
  localparam int IDX_W = ADDR_W - 1;
  localparam int NRD   = 2;

  // Read-port vectors
  logic [ADDR_W-1:0] rd_addr_v [NRD];
  logic [NRD-1:0]    rd_en_v, rd_spec_v, rd_bad_v;
  logic [IDX_W-1:0]  rd_idx_v  [NRD];
  spec_sel_e         rd_sel_v  [NRD];
  logic [DATA_W-1:0] gpr_rd_v  [NRD];
  logic [DATA_W-1:0] rd_mux_v  [NRD];

  // Write-port decode
  logic              w_spec, w_bad;
  logic [IDX_W-1:0]  w_idx;
  spec_sel_e         w_sel;
  logic              gpr_we, spec_we, err_hit;

  // Special registers
  logic [DATA_W-1:0] g_q, d_q, pc_q;
  logic [FLAG_W-1:0] flag_q;

  assign rd_addr_v[0] = rd_addr_a;
  assign rd_addr_v[1] = rd_addr_b;
  assign rd_en_v      = {rd_en_b, rd_en_a};
  assign rd_data_a    = rd_mux_v[0];
  assign rd_data_b    = rd_mux_v[1];

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_port
      regwin_addr_dec #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) u_dec (
        .addr    (rd_addr_v[p]),
        .is_spec (rd_spec_v[p]),
        .bad_idx (rd_bad_v[p]),
        .gpr_idx (rd_idx_v[p]),
        .sel     (rd_sel_v[p])
      );

      always_comb begin
        if (rd_bad_v[p]) begin
          rd_mux_v[p] = '0;
        end else if (rd_spec_v[p]) begin
          case (rd_sel_v[p])
            SP_G:    rd_mux_v[p] = g_q;
            SP_D:    rd_mux_v[p] = d_q;
            SP_PC:   rd_mux_v[p] = pc_q;
            SP_FLAG: rd_mux_v[p] = {{(DATA_W-FLAG_W){1'b0}}, flag_q};
            default: rd_mux_v[p] = '0;
          endcase
        end else begin
          rd_mux_v[p] = gpr_rd_v[p];
        end
      end
    end
  endgenerate

  regwin_addr_dec #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) u_wdec (
    .addr    (wr_addr),
    .is_spec (w_spec),
    .bad_idx (w_bad),
    .gpr_idx (w_idx),
    .sel     (w_sel)
  );

  assign gpr_we  = wr_en && !w_spec && !w_bad;
  assign spec_we = wr_en && w_spec;
  assign err_hit = (|(rd_en_v & rd_bad_v)) || (wr_en && w_bad);

  regwin_gpr_bank #(
    .DATA_W(DATA_W), .NUM_GPR(NUM_GPR), .IDX_W(IDX_W), .NRD(NRD)
  ) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (gpr_we),
    .widx  (w_idx),
    .wdata (wr_data),
    .ridx  (rd_idx_v),
    .rdata (gpr_rd_v)
  );

  regwin_spec_regs #(.DATA_W(DATA_W)) u_spec (
    .clk      (clk),
    .rst      (rst),
    .we       (spec_we),
    .sel      (w_sel),
    .wdata    (wr_data),
    .flag_set (flag_set),
    .flag_clr (flag_clr),
    .pc_inc   (pc_inc),
    .g_q      (g_q),
    .d_q      (d_q),
    .pc_q     (pc_q),
    .flag_q   (flag_q)
  );

  // Sticky error: a new hit wins over a clear.
  always_ff @(posedge clk) begin
    if (rst)          reg_err <= 1'b0;
    else if (err_hit) reg_err <= 1'b1;
    else if (err_clr) reg_err <= 1'b0;
  end

  assign pc_value   = pc_q;
  assign flag_value = flag_q;

  // R4: the error stays up unless cleared.
  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_err && !err_clr) |=> reg_err);

  // R4: an illegal write always raises the error.
  p_err_raise_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_bad) |=> reg_err);

  // R4: a clear with no competing hit drops the error.
  p_err_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (err_clr && !err_hit) |=> !reg_err);

endmodule

// File: tb/sim_regwin_file.sv
module sim_regwin_file;
  localparam int CLK_P = 10;
  localparam int NV    = 10;

  // {wr_addr[75:70], wr_data[69:38], rd_addr[37:32], expected[31:0]}
  localparam logic [75:0] VEC [NV] = '{
    {6'd0,  32'h1111_1111, 6'd0,  32'h1111_1111},
    {6'd23, 32'hA5A5_A5A5, 6'd23, 32'hA5A5_A5A5},
    {6'd5,  32'h0000_0055, 6'd0,  32'h1111_1111},
    {6'h20, 32'hDEAD_BEEF, 6'h20, 32'hDEAD_BEEF},
    {6'h21, 32'h1234_5678, 6'h20, 32'hDEAD_BEEF},
    {6'h3D, 32'hCAFE_F00D, 6'h21, 32'hCAFE_F00D},
    {6'h22, 32'h0000_0100, 6'h22, 32'h0000_0100},
    {6'h23, 32'hFFFF_FFF5, 6'h23, 32'h0000_0005},
    {6'd24, 32'h7777_7777, 6'd23, 32'hA5A5_A5A5},
    {6'd5,  32'h0000_0000, 6'd5,  32'h0000_0000}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R2", "R1", "R6",
                                  "R1", "R7", "R5", "R3", "R2"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en_a = 1'b1, rd_en_b = 1'b1;
  logic [5:0]  rd_addr_a = '0, rd_addr_b = '0;
  logic [31:0] rd_data_a, rd_data_b;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  flag_set = '0, flag_clr = '0;
  logic        pc_inc = 1'b0, err_clr = 1'b0;
  logic        reg_err;
  logic [31:0] pc_value;
  logic [3:0]  flag_value;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  regwin_file #(.DATA_W(32), .ADDR_W(6), .NUM_GPR(24)) u0 (
    .clk(clk), .rst(rst),
    .rd_en_a(rd_en_a), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_en_b(rd_en_b), .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_set(flag_set), .flag_clr(flag_clr), .pc_inc(pc_inc),
    .err_clr(err_clr), .reg_err(reg_err),
    .pc_value(pc_value), .flag_value(flag_value)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    // R8: state while reset is held
    repeat (3) tick();
    rd_addr_a = 6'd0; rd_addr_b = 6'h22; #1;
    check("R8", "gpr0 in reset", rd_data_a, 32'h0);
    check("R8", "pc in reset", rd_data_b, 32'h0);
    check("R8", "err in reset", {31'b0, reg_err}, 32'h0);
    check("R8", "flags in reset", {28'b0, flag_value}, 32'h0);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      wr_en = 1'b1; wr_addr = VEC[i][75:70]; wr_data = VEC[i][69:38];
      rd_addr_a = VEC[i][37:32];
      tick();
      wr_en = 1'b0; #1;
      check(VTAG[i], $sformatf("vector %0d", i), rd_data_a, VEC[i][31:0]);
    end

    // R4: the illegal write in the table left the error set
    check("R4", "err after illegal write", {31'b0, reg_err}, 32'h1);
    // R3: no aliasing of the refused write
    rd_addr_a = 6'd0; rd_addr_b = 6'h22; #1;
    check("R3", "gpr0 untouched", rd_data_a, 32'h1111_1111);
    check("R2", "port B reads pc", rd_data_b, 32'h0000_0100);

    // R2: same-cycle read returns the old value
    rd_addr_a = 6'd5; wr_en = 1'b1; wr_addr = 6'd5; wr_data = 32'h5A5A_0000; #1;
    check("R2", "read before edge", rd_data_a, 32'h0);
    tick(); wr_en = 1'b0; #1;
    check("R2", "read after edge", rd_data_a, 32'h5A5A_0000);

    // R4: clear
    err_clr = 1'b1; tick(); err_clr = 1'b0; #1;
    check("R4", "err cleared", {31'b0, reg_err}, 32'h0);

    // R3/R4: illegal read
    rd_addr_b = 6'd30; #1;
    check("R3", "illegal read zero", rd_data_b, 32'h0);
    tick(); #1;
    check("R4", "err from read", {31'b0, reg_err}, 32'h1);
    rd_addr_b = 6'd28; err_clr = 1'b1; tick(); err_clr = 1'b0; #1;
    check("R4", "hit beats clear", {31'b0, reg_err}, 32'h1);
    rd_addr_b = 6'h22; err_clr = 1'b1; tick(); err_clr = 1'b0; #1;
    check("R4", "clear after race", {31'b0, reg_err}, 32'h0);
    rd_en_b = 1'b0; rd_addr_b = 6'd30; tick(); #1;
    check("R4", "disabled port no err", {31'b0, reg_err}, 32'h0);
    rd_en_b = 1'b1; rd_addr_b = 6'h22;

    // R5: flag bits (currently 0101)
    rd_addr_a = 6'h23;
    flag_set = 4'b0010; tick(); flag_set = '0; #1;
    check("R5", "set zero flag", rd_data_a, 32'h7);
    flag_clr = 4'b0001; tick(); flag_clr = '0; #1;
    check("R5", "clear overflow", rd_data_a, 32'h6);
    flag_set = 4'b1000; flag_clr = 4'b1000; tick(); flag_set = '0; flag_clr = '0; #1;
    check("R5", "set beats clear", {28'b0, flag_value}, 32'hE);
    wr_en = 1'b1; wr_addr = 6'h23; wr_data = 32'h0; flag_set = 4'b0001;
    tick(); wr_en = 1'b0; flag_set = '0; #1;
    check("R5", "set over write", rd_data_a, 32'h1);

    // R7: program counter
    pc_inc = 1'b1; tick(); pc_inc = 1'b0; #1;
    check("R7", "pc step", pc_value, 32'h101);
    pc_inc = 1'b1; wr_en = 1'b1; wr_addr = 6'h22; wr_data = 32'h200;
    tick(); pc_inc = 1'b0; wr_en = 1'b0; #1;
    check("R7", "write beats step", pc_value, 32'h200);
    pc_inc = 1'b1; wr_en = 1'b1; wr_addr = 6'h20; wr_data = 32'h0BAD_F00D;
    tick(); pc_inc = 1'b0; wr_en = 1'b0; #1;
    check("R7", "step with G write", pc_value, 32'h201);
    rd_addr_a = 6'h20; rd_addr_b = 6'h21; #1;
    check("R6", "G written", rd_data_a, 32'h0BAD_F00D);
    check("R6", "D untouched", rd_data_b, 32'hCAFE_F00D);

    // R8: reset clears everything, including a pending error
    wr_en = 1'b1; wr_addr = 6'd24; wr_data = 32'h1; tick(); wr_en = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0; #1;
    check("R8", "err after reset", {31'b0, reg_err}, 32'h0);
    check("R8", "G after reset", rd_data_a, 32'h0);
    check("R8", "D after reset", rd_data_b, 32'h0);
    check("R8", "pc after reset", pc_value, 32'h0);
    check("R8", "flags after reset", {28'b0, flag_value}, 32'h0);
    rd_addr_a = 6'd23; rd_addr_b = 6'd0; #1;
    check("R8", "gpr23 after reset", rd_data_a, 32'h0);
    check("R8", "gpr0 after reset", rd_data_b, 32'h0);

    report();
    $finish;
  end

endmodule